// File: doc/BRIEF.md
# Timed Column Strobe Multiplexer

This block drives the column enables of an LED matrix that is refreshed one column at a time. A driver stage upstream raises a one-cycle ready pulse each time it has latched the data for a column. On that pulse the block switches on exactly one column for a fixed number of clock cycles and then turns every column off again. It stays dark until the next pulse arrives. Columns are visited in ascending order and the sequence wraps after the last one.

The LEDs are driven above their continuous rating, so the on-time has a hard ceiling strictly under 10 µs. The on-time is a cycle-count parameter, and its default is derived from the clock frequency given in MHz. A requested on-time that would reach 10 µs is clamped below that ceiling when the block is elaborated. A slice-restart pulse brings the column order back to column 0 after an early slice change. A ready pulse that arrives while a column is still lit ends that column and starts the next one, so two columns are never lit together.

Top module: `col_strobe_mux`

## Requirements
- R1: After reset, and until the first ready pulse, `col_en` is all zeros.
- R2: On the clock edge that samples `col_ready` high, `col_en` becomes a word with exactly one bit set. Bit k set means column k is lit. `col_en` never has more than one bit set.
- R3: A lit column stays lit for exactly T cycles and then goes dark, provided no new ready pulse arrives meanwhile. T is min(`ON_CYCLES`, `CLK_MHZ`*10-1). The default `ON_CYCLES` is `CLK_MHZ`*9.
- R4: Once the on-time has expired, `col_en` stays all zeros until the next ready pulse.
- R5: Successive ready pulses light bit 0, bit 1, and so on up to bit `NUM_COLS`-1. The next pulse then lights bit 0 again.
- R6: A `slice_restart` pulse makes the next lit column bit 0. If it coincides with a ready pulse, that pulse lights bit 0 and the following pulse lights bit 1. A restart without a ready pulse leaves the currently lit column and its remaining time unchanged.
- R7: A ready pulse while a column is lit switches at once to the next column. The new column then gets a full T cycles of on-time.
- R8: An `ON_CYCLES` value of `CLK_MHZ`*10 or more is clamped to `CLK_MHZ`*10-1 cycles, so the on-time stays strictly under 10 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_ready | input | 1 | One-cycle pulse: column data latched, light the next column |
| slice_restart | input | 1 | One-cycle pulse: realign the column order to column 0 |
| col_en | output | NUM_COLS | One-hot column enable, registered |

## Verification
The hardest situations to reach from the ports are a ready pulse that lands while a column is still lit, and a restart that coincides with a ready pulse. Both upset the index and the timer at the same edge. A vector table drives back-to-back pulses cycle by cycle, mixing lone restarts, coincident restarts and idle cycles, and checks the one-hot output after every edge. Directed runs then measure the full on-time after a mid-pulse re-trigger. A second instance, built with an over-limit on-time, shows the clamp at its 10 µs boundary.

// File: rtl/colmux_pkg.sv
package colmux_pkg;

  // Largest on-time (cycles) strictly below 10 us at the given clock in MHz.
  function automatic int max_on_cycles(input int clk_mhz);
    return clk_mhz * 10 - 1;
  endfunction

  // Clamp a requested on-time into [1, limit].
  function automatic int clamp_on(input int req, input int limit);
    if (req > limit) return limit;
    if (req < 1) return 1;
    return req;
  endfunction

  // Next column index with wrap.
  function automatic int next_col(input int cur, input int ncols);
    return (cur >= ncols - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/colmux_colindex.sv
module colmux_colindex #(
  parameter int NUM_COLS = 8,
  localparam int IDX_W = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic             restart,
  output logic [IDX_W-1:0] sel
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] nxt;

  // Column lit by a pulse in this cycle; a restart forces column 0.
  assign sel = restart ? '0 : idx_q;

  always_comb begin
    if (sel == IDX_W'(NUM_COLS - 1)) nxt = '0;
    else                             nxt = sel + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          idx_q <= '0;
    else if (ready)   idx_q <= nxt;
    else if (restart) idx_q <= '0;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) < NUM_COLS); // R5
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ready && !restart && idx_q == IDX_W'(NUM_COLS - 1)) |=> idx_q == '0); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (restart && !ready) |=> idx_q == '0); // R6
endmodule

// File: rtl/colmux_ontimer.sv
module colmux_ontimer #(
  parameter int ON_TICKS = 36,
  localparam int TW = $clog2(ON_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expire
);
  logic [TW-1:0] cnt_q;

  // Last lit cycle reached and no new pulse overriding it.
  assign expire = (cnt_q == TW'(1)) && !start;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (start)       cnt_q <= TW'(ON_TICKS);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  AST_TIMER_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TW'(ON_TICKS)); // R8
  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == TW'(ON_TICKS)); // R7
endmodule

// File: rtl/colmux_colreg.sv
module colmux_colreg #(
  parameter int NUM_COLS = 8,
  localparam int IDX_W = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ready,
  input  logic                expire,
  input  logic [IDX_W-1:0]    sel,
  output logic [NUM_COLS-1:0] col_en
);
  logic [NUM_COLS-1:0] onehot;

  assign onehot = {{(NUM_COLS - 1){1'b0}}, 1'b1} << sel;

  always_ff @(posedge clk) begin
    if (rst)         col_en <= '0;
    else if (ready)  col_en <= onehot;
    else if (expire) col_en <= '0;
  end

  AST_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_en)); // R2
  AST_DARK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ready && col_en == '0) |=> col_en == '0); // R4
endmodule

// File: rtl/col_strobe_mux.sv
module col_strobe_mux #(
  parameter int NUM_COLS  = 8,
  parameter int CLK_MHZ   = 250,
  parameter int ON_CYCLES = CLK_MHZ * 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                col_ready,
  input  logic                slice_restart,
  output logic [NUM_COLS-1:0] col_en
);
  localparam int LIMIT  = colmux_pkg::max_on_cycles(CLK_MHZ);
  localparam int EFF_ON = colmux_pkg::clamp_on(ON_CYCLES, LIMIT);
  localparam int IDX_W  = $clog2(NUM_COLS);

  logic [IDX_W-1:0] sel;
  logic             expire;

  colmux_colindex #(.NUM_COLS(NUM_COLS)) idx_i (
    .clk(clk), .rst(rst), .ready(col_ready), .restart(slice_restart), .sel(sel)
  );

  colmux_ontimer #(.ON_TICKS(EFF_ON)) tmr_i (
    .clk(clk), .rst(rst), .start(col_ready), .expire(expire)
  );

  colmux_colreg #(.NUM_COLS(NUM_COLS)) reg_i (
    .clk(clk), .rst(rst), .ready(col_ready), .expire(expire), .sel(sel),
    .col_en(col_en)
  );

  AST_READY_LIGHTS: assert property (@(posedge clk) disable iff (rst)
    col_ready |=> $countones(col_en) == 1); // R2
  AST_EXPIRE_DARK: assert property (@(posedge clk) disable iff (rst)
    expire |=> col_en == '0); // R3
  AST_RESTART_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (slice_restart && !col_ready && !expire) |=> $stable(col_en)); // R6
endmodule

// File: tb/col_strobe_mux_tb_top.sv
module col_strobe_mux_tb_top;
  localparam int NC = 8;
  localparam int MHZ = 4;
  localparam int T_DEF = MHZ * 9;      // 36
  localparam int T_CAP = MHZ * 10 - 1; // 39

  logic clk = 0, rst = 1, rdy = 0, rs = 0;
  logic [NC-1:0] en_d, en_c;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  col_strobe_mux #(.NUM_COLS(NC), .CLK_MHZ(MHZ)) dut_i (
    .clk(clk), .rst(rst), .col_ready(rdy), .slice_restart(rs), .col_en(en_d));
  col_strobe_mux #(.NUM_COLS(NC), .CLK_MHZ(MHZ), .ON_CYCLES(100)) cap_i (
    .clk(clk), .rst(rst), .col_ready(rdy), .slice_restart(rs), .col_en(en_c));

  // {restart, ready, expected col_en}
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {2'b01, 8'h01}, {2'b01, 8'h02}, {2'b00, 8'h02}, {2'b01, 8'h04},
    {2'b10, 8'h04}, {2'b01, 8'h01}, {2'b01, 8'h02}, {2'b11, 8'h01},
    {2'b01, 8'h02}, {2'b01, 8'h04}, {2'b01, 8'h08}, {2'b01, 8'h10},
    {2'b01, 8'h20}, {2'b01, 8'h40}, {2'b01, 8'h80}, {2'b01, 8'h01},
    {2'b00, 8'h01}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic s);
    @(negedge clk); rdy = r; rs = s;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  // Count lit cycles of both instances after a pulse already applied.
  task automatic measure(output int nd, output int nc);
    nd = 0; nc = 0;
    for (int i = 0; i < 200; i++) begin
      if (en_d != 0) nd++;
      if (en_c != 0) nc++;
      if (en_d == 0 && en_c == 0) break;
      step(0, 0);
    end
  endtask

  initial begin
    int nd, nc;
    idle(3);
    chk("R1 reset", int'(en_d), 0);
    @(negedge clk); rst = 0;
    idle(5);
    chk("R1 idle after reset", int'(en_d), 0);
    chk("R1 idle after reset cap", int'(en_c), 0);

    // Table: back-to-back pulses, restarts, wrap (R2 R5 R6 R7)
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][8], VEC[v][9]);
      chk($sformatf("R2/R5/R6/R7 vector %0d", v), int'(en_d), int'(VEC[v][7:0]));
    end
    idle(45);
    chk("R4 dark after table", int'(en_d), 0);

    // R3 / R8: on-time lengths
    step(0, 1);                 // realign to column 0
    step(1, 0);
    measure(nd, nc);
    chk("R3 default on-time", nd, T_DEF);
    chk("R8 clamped on-time", nc, T_CAP);
    idle(20);
    chk("R4 stays dark", int'(en_d | en_c), 0);

    // R7: re-trigger mid-pulse gives full on-time on next column
    step(1, 0);                 // column 1
    idle(10);
    step(1, 0);                 // column 2
    chk("R7 switch column", int'(en_d), 8'h04);
    measure(nd, nc);
    chk("R7 full retime", nd, T_DEF);

    // R6: restart while lit keeps column and its time
    step(1, 0);                 // column 3
    idle(5);
    step(0, 1);
    chk("R6 restart keeps lit", int'(en_d), 8'h08);
    measure(nd, nc);
    chk("R6 restart keeps time", nd, T_DEF - 6);

    // R5: full ordered sweep with gaps, then wrap
    for (int k = 0; k <= NC; k++) begin
      step(1, 0);
      chk($sformatf("R5 sweep col %0d", k), int'(en_d), 1 << (k % NC));
      idle(T_CAP + 2);
      chk("R4 dark between", int'(en_d | en_c), 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule